// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block moves a contiguous, word-aligned range of memory out onto a valid/ready stream as one packet. Software sets up the channel through four 32-bit registers: control, status, source address and length. The channel then fetches the range with burst read requests and forwards each returned word as one stream beat. The final beat carries a last marker.

Writing the length register is the start command. A running, idle channel with aligned values begins a transfer. Any other length write is refused and raises a sticky error flag. Completion and error each raise their own interrupt line, and each line has its own enable bit.

Back-pressure is carried through the whole path. The memory response is accepted only when the single output slot can take a word. Once the slot presents a beat, it holds data, valid and last unchanged until the consumer raises ready. A burst request is held steady until the memory side accepts it. Only one burst is outstanding at a time.

Top module: `m2s_dma_chan`

## Requirements
- R1: After reset the status register reads 1 (idle bit 0 set, completion bit 1 and error bit 2 clear), no stream beat or read request is valid, and both interrupt lines are low.
- R2: With run set and the channel idle, writing a nonzero length L (multiple of 4) while the source register holds an aligned address S produces exactly L/4 stream beats. Beat k carries the memory word at byte address S+4k.
- R3: Read requests ask for between 1 and 16 beats. Successive requests of one transfer start where the previous one ended. The request address is 4-byte aligned. Address and beat count stay stable while the request waits for ready.
- R4: Last is high on the final beat of a transfer and on no other beat. While valid is high and ready is low, the beat's data and last hold and valid stays high.
- R5: When the final beat is accepted, status bit 1 (completion) sets and status bit 0 (idle) returns to 1.
- R6: A length write while control bit 0 (run) is clear starts nothing (no request, no beat) and sets status bit 2 (error).
- R7: A length write during an active transfer is refused and sets the error bit. The running transfer still delivers all its beats intact.
- R8: A length write is refused and sets the error bit when the length or the source address has a nonzero value in bits 1:0.
- R9: A length write of zero on a running, idle channel issues no read and no beat, and sets the completion bit at once.
- R10: Writing status with bit 1 or bit 2 set clears that flag. Writing 0 to a flag bit leaves the flag unchanged.
- R11: Control bit 1 enables the completion interrupt and control bit 2 the error interrupt. Each interrupt line equals its flag ANDed with its enable.
- R12: Register offsets are 0 control, 1 status, 2 source address, 3 length. Control and source may be written in either order before the length write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| rd_req_valid | output | 1 | Burst read request valid |
| rd_req_ready | input | 1 | Burst read request accepted |
| rd_req_addr | output | ADDR_W | Burst start byte address |
| rd_req_beats | output | 5 | Beats in the burst (1..MAX_BURST) |
| rd_rsp_valid | input | 1 | Read data word valid |
| rd_rsp_ready | output | 1 | Read data word accepted |
| rd_rsp_data | input | DATA_W | Read data word |
| m_valid | output | 1 | Stream beat valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | DATA_W | Stream beat data |
| m_last | output | 1 | Final beat of the packet |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions assume the memory side answers each accepted request with exactly the number of words it asked for, in order. They also assume no response word arrives while no burst is pending. The bench memory model tracks one burst at a time and keeps a response word valid until it is taken, so the stimulus stays within those assumptions. Ready on both the request and the stream side follows fixed cycle patterns that include long stalls, so the hold rules are exercised. Error cases are only injected through register writes, never through protocol violations.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_SRC  = 2'd2;
  localparam logic [1:0] REG_LEN  = 2'd3;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_DIE = 1;
  localparam int CTRL_EIE = 2;
  localparam int STAT_IDLE = 0;
  localparam int STAT_DONE = 1;
  localparam int STAT_ERR  = 2;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_REQ  = 2'd1,
    RD_DATA = 2'd2
  } rd_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int DATA_W = 32,
  localparam int BSH     = $clog2(DATA_W / 8),
  localparam int WORDS_W = LEN_W - BSH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [1:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic               done_pulse,
  output logic               start,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [WORDS_W-1:0] start_words,
  output logic               busy,
  output logic               irq_done,
  output logic               irq_err
);
  logic              run_q, die_q, eie_q;
  logic              done_q, err_q, busy_q;
  logic [ADDR_W-1:0] src_q;
  logic [LEN_W-1:0]  len_q;
  logic              len_cmd, refuse, zero_len;
  logic              src_bad, len_bad;

  always_comb begin
    len_cmd  = wr_en && (wr_addr == REG_LEN);
    src_bad  = (src_q[BSH-1:0] != '0);
    len_bad  = (wr_data[BSH-1:0] != '0);
    refuse   = len_cmd && (!run_q || busy_q || src_bad || len_bad);
    zero_len = len_cmd && !refuse && (wr_data[LEN_W-1:BSH] == '0);
    start    = len_cmd && !refuse && !zero_len;
  end

  assign start_addr  = src_q;
  assign start_words = wr_data[LEN_W-1:BSH];
  assign busy        = busy_q;
  assign irq_done    = done_q & die_q;
  assign irq_err     = err_q & eie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      die_q  <= 1'b0;
      eie_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      busy_q <= 1'b0;
      src_q  <= '0;
      len_q  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          REG_CTRL: begin
            run_q <= wr_data[CTRL_RUN];
            die_q <= wr_data[CTRL_DIE];
            eie_q <= wr_data[CTRL_EIE];
          end
          REG_STAT: begin
            if (wr_data[STAT_DONE]) done_q <= 1'b0;
            if (wr_data[STAT_ERR])  err_q  <= 1'b0;
          end
          REG_SRC: src_q <= wr_data[ADDR_W-1:0];
          default: len_q <= wr_data[LEN_W-1:0];
        endcase
      end
      if (refuse)     err_q  <= 1'b1;
      if (zero_len)   done_q <= 1'b1;
      if (start)      busy_q <= 1'b1;
      if (done_pulse) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_data[CTRL_RUN] = run_q;
        rd_data[CTRL_DIE] = die_q;
        rd_data[CTRL_EIE] = eie_q;
      end
      REG_STAT: begin
        rd_data[STAT_IDLE] = ~busy_q;
        rd_data[STAT_DONE] = done_q;
        rd_data[STAT_ERR]  = err_q;
      end
      REG_SRC: rd_data = 32'(src_q);
      default: rd_data = 32'(len_q);
    endcase
  end
endmodule

// File: rtl/dma_reader.sv
module dma_reader
  import dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int WORDS_W   = 30,
  parameter int MAX_BURST = 16,
  localparam int BSH     = $clog2(DATA_W / 8),
  localparam int BURST_W = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [WORDS_W-1:0] start_words,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               beat_valid,
  input  logic               beat_ready,
  output logic [DATA_W-1:0]  beat_data,
  output logic               beat_last
);
  rd_state_t          state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORDS_W-1:0] left_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] burst_len;
  logic               req_hs, rsp_hs;

  always_comb begin
    if (left_q > WORDS_W'(MAX_BURST)) burst_len = BURST_W'(MAX_BURST);
    else                              burst_len = BURST_W'(left_q);
  end

  assign req_valid  = (state_q == RD_REQ);
  assign req_addr   = addr_q;
  assign req_beats  = burst_len;
  assign rsp_ready  = (state_q == RD_DATA) && beat_ready;
  assign beat_valid = (state_q == RD_DATA) && rsp_valid;
  assign beat_data  = rsp_data;
  assign beat_last  = (left_q == WORDS_W'(1));
  assign req_hs     = req_valid && req_ready;
  assign rsp_hs     = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        RD_IDLE: if (start) begin
          addr_q  <= start_addr;
          left_q  <= start_words;
          state_q <= RD_REQ;
        end
        RD_REQ: if (req_hs) begin
          cnt_q   <= burst_len;
          addr_q  <= addr_q + (ADDR_W'(burst_len) << BSH);
          state_q <= RD_DATA;
        end
        RD_DATA: if (rsp_hs) begin
          left_q <= left_q - WORDS_W'(1);
          cnt_q  <= cnt_q - BURST_W'(1);
          if (cnt_q == BURST_W'(1))
            state_q <= (left_q == WORDS_W'(1)) ? RD_IDLE : RD_REQ;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_stream_out.sv
module dma_stream_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              done_pulse
);
  logic              v_q;
  logic [DATA_W-1:0] d_q;
  logic              l_q;

  assign in_ready   = !v_q || out_ready;
  assign out_valid  = v_q;
  assign out_data   = d_q;
  assign out_last   = l_q;
  assign done_pulse = v_q && out_ready && l_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
      l_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      v_q <= 1'b1;
      d_q <= in_data;
      l_q <= in_last;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/m2s_dma_chan.sv
module m2s_dma_chan #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MAX_BURST = 16,
  localparam int BSH     = $clog2(DATA_W / 8),
  localparam int WORDS_W = LEN_W - BSH,
  localparam int BURST_W = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_wr_addr,
  input  logic [31:0]        reg_wr_data,
  input  logic [1:0]         reg_rd_addr,
  output logic [31:0]        reg_rd_data,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  output logic [BURST_W-1:0] rd_req_beats,
  input  logic               rd_rsp_valid,
  output logic               rd_rsp_ready,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [DATA_W-1:0]  m_data,
  output logic               m_last,
  output logic               irq_done,
  output logic               irq_err
);
  logic               start_w, busy_w, done_w;
  logic [ADDR_W-1:0]  saddr_w;
  logic [WORDS_W-1:0] swords_w;
  logic               bv_w, br_w, bl_w;
  logic [DATA_W-1:0]  bd_w;

  dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .done_pulse(done_w), .start(start_w),
    .start_addr(saddr_w), .start_words(swords_w),
    .busy(busy_w), .irq_done(irq_done), .irq_err(irq_err)
  );

  dma_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_W(WORDS_W),
               .MAX_BURST(MAX_BURST)) rd_i (
    .clk(clk), .rst_n(rst_n),
    .start(start_w), .start_addr(saddr_w), .start_words(swords_w),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .req_addr(rd_req_addr), .req_beats(rd_req_beats),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready), .rsp_data(rd_rsp_data),
    .beat_valid(bv_w), .beat_ready(br_w), .beat_data(bd_w), .beat_last(bl_w)
  );

  dma_stream_out #(.DATA_W(DATA_W)) so_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(bv_w), .in_ready(br_w), .in_data(bd_w), .in_last(bl_w),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data),
    .out_last(m_last), .done_pulse(done_w)
  );
endmodule

// File: rtl/m2s_dma_chk.sv
module m2s_dma_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 16,
  localparam int BURST_W = $clog2(MAX_BURST + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [ADDR_W-1:0]  rd_req_addr,
  input logic [BURST_W-1:0] rd_req_beats,
  input logic               m_valid,
  input logic               m_ready,
  input logic [DATA_W-1:0]  m_data,
  input logic               m_last,
  input logic               busy
);
  assert_stream_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_beats)));

  assert_burst_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_beats != '0 && rd_req_beats <= BURST_W'(MAX_BURST)));

  assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

  assert_beat_in_transfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid || rd_req_valid) |-> busy);
endmodule

bind m2s_dma_chan m2s_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_req_beats(rd_req_beats),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .busy(busy_w)
);

// File: tb/m2s_dma_chan_tb_top.sv
`timescale 1ns/1ps
module m2s_dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic [4:0]  rd_req_beats;
  logic        rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic        m_valid, m_ready = 1'b0, m_last;
  logic [31:0] m_data;
  logic        irq_done, irq_err;

  always #5 clk = ~clk;

  m2s_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_beats(rd_req_beats),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  int errors = 0, checks = 0;
  int cyc = 0, mode = 0;
  int beat_idx = 0, exp_words = 0, nreq = 0;
  logic [31:0] exp_src = '0, exp_next = '0;
  logic [31:0] mem_addr = '0;
  int mem_left = 0;
  bit rsp_taken = 0, hold_pend = 0;
  logic [31:0] hold_data = '0;
  logic hold_last = 1'b0;

  function automatic logic [31:0] fdata(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model and stream consumer: inputs change only right after negedge,
  // handshakes are evaluated 1 ns later, ahead of the next rising edge.
  always @(negedge clk) begin
    cyc++;
    case (mode)
      0: begin m_ready = 1'b1; rd_req_ready = 1'b1; end
      1: begin m_ready = (cyc % 3) != 0; rd_req_ready = (cyc % 2) == 0; end
      default: begin m_ready = (cyc % 7) < 2; rd_req_ready = (cyc % 5) == 1; end
    endcase
    if (rsp_taken) begin rd_rsp_valid = 1'b0; rsp_taken = 0; end
    if (!rd_rsp_valid && mem_left > 0 && (mode == 0 || (cyc % 4) != 1)) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = fdata(mem_addr);
    end
    #1;
    if (hold_pend) begin
      chk(m_valid && m_data == hold_data && m_last == hold_last,
          "R4 hold under stall", m_data, hold_data);
      hold_pend = 0;
    end
    if (rd_req_valid && rd_req_ready) begin
      chk(rd_req_addr == exp_next, "R3 burst contiguous", rd_req_addr, exp_next);
      chk(rd_req_beats >= 1 && rd_req_beats <= 16, "R3 burst size", 32'(rd_req_beats), 32'd16);
      mem_addr = rd_req_addr;
      mem_left = int'(rd_req_beats);
      exp_next = rd_req_addr + 32'(rd_req_beats) * 4;
      nreq++;
    end
    if (rd_rsp_valid && rd_rsp_ready) begin
      mem_addr  = mem_addr + 4;
      mem_left--;
      rsp_taken = 1;
    end
    if (m_valid && m_ready) begin
      chk(beat_idx < exp_words, "R2 unexpected beat", 32'(beat_idx), 32'(exp_words));
      chk(m_data == fdata(exp_src + 32'(beat_idx) * 4), "R2 beat data",
          m_data, fdata(exp_src + 32'(beat_idx) * 4));
      chk(m_last == (beat_idx == exp_words - 1), "R4 last marker",
          32'(m_last), 32'(beat_idx == exp_words - 1));
      beat_idx++;
    end else if (m_valid) begin
      hold_pend = 1;
      hold_data = m_data;
      hold_last = m_last;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      rd(2'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic arm(input logic [31:0] src, input int words);
    exp_src = src; exp_next = src; exp_words = words; beat_idx = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] s;
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, s);
    chk(s == 32'h1, "R1 status after reset", s, 32'h1);
    chk(!m_valid && !rd_req_valid && !irq_done && !irq_err, "R1 outputs idle",
        {m_valid, rd_req_valid, irq_done, irq_err}, 32'h0);

    // R6: length write while stopped
    wr(2'd0, 32'h4);
    wr(2'd2, 32'h2000);
    arm(32'h2000, 0);
    n0 = nreq;
    wr(2'd3, 32'd32);
    repeat (10) @(negedge clk);
    rd(2'd1, s);
    chk(s == 32'h5, "R6 refused while stopped sets error", s, 32'h5);
    chk(nreq == n0 && beat_idx == 0, "R6 nothing transferred", 32'(nreq - n0), 32'h0);
    chk(irq_err == 1'b1, "R11 error irq enabled", 32'(irq_err), 32'h1);

    // R10: zero write keeps, one write clears
    wr(2'd1, 32'h0);
    rd(2'd1, s);
    chk(s[2] == 1'b1, "R10 zero write keeps error", s, 32'h5);
    wr(2'd1, 32'h4);
    rd(2'd1, s);
    chk(s == 32'h1, "R10 W1C clears error", s, 32'h1);
    chk(irq_err == 1'b0, "R11 error irq follows flag", 32'(irq_err), 32'h0);

    // R8: misaligned source, then misaligned length (error irq disabled)
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h3002);
    n0 = nreq;
    wr(2'd3, 32'd16);
    repeat (5) @(negedge clk);
    rd(2'd1, s);
    chk(s == 32'h5, "R8 misaligned source refused", s, 32'h5);
    chk(irq_err == 1'b0, "R11 error irq masked", 32'(irq_err), 32'h0);
    wr(2'd1, 32'h4);
    wr(2'd2, 32'h3000);
    wr(2'd3, 32'd6);
    repeat (5) @(negedge clk);
    rd(2'd1, s);
    chk(s == 32'h5, "R8 misaligned length refused", s, 32'h5);
    chk(nreq == n0 && beat_idx == 0, "R8 nothing transferred", 32'(nreq - n0), 32'h0);
    wr(2'd1, 32'h4);

    // R9: zero length
    wr(2'd0, 32'h3);
    n0 = nreq;
    wr(2'd3, 32'd0);
    rd(2'd1, s);
    chk(s == 32'h3, "R9 zero length completes at once", s, 32'h3);
    chk(irq_done == 1'b1, "R11 done irq enabled", 32'(irq_done), 32'h1);
    repeat (5) @(negedge clk);
    chk(nreq == n0 && beat_idx == 0, "R9 no read, no beat", 32'(nreq - n0), 32'h0);
    wr(2'd1, 32'h2);
    chk(irq_done == 1'b0, "R10 W1C clears done", 32'(irq_done), 32'h0);

    // R2/R3/R4/R5/R12 sweep: source written before control, all ready patterns
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int w = 1; w <= 36; w++) begin
        logic [31:0] src;
        src = 32'h1_0000 + 32'(m) * 32'h1000 + 32'(w) * 32'h40;
        wr(2'd1, 32'h6);
        wr(2'd2, src);
        wr(2'd0, (w % 2 == 0) ? 32'h3 : 32'h1);
        arm(src, w);
        wr(2'd3, 32'(w) * 4);
        wait_idle();
        rd(2'd1, s);
        chk(beat_idx == w, "R2 beat count", 32'(beat_idx), 32'(w));
        chk(s == 32'h3, "R5 done and idle", s, 32'h3);
        chk(irq_done == (w % 2 == 0), "R11 done irq gating", 32'(irq_done), 32'(w % 2 == 0));
      end
    end

    // R7: length write during an active transfer
    mode = 1;
    wr(2'd1, 32'h6);
    wr(2'd2, 32'h8000);
    arm(32'h8000, 24);
    wr(2'd3, 32'd96);
    wr(2'd3, 32'd8);
    rd(2'd1, s);
    chk(s[2] == 1'b1 && s[0] == 1'b0, "R7 busy length write refused", s, 32'h4);
    wait_idle();
    rd(2'd1, s);
    chk(beat_idx == 24, "R7 running transfer intact", 32'(beat_idx), 32'd24);
    chk(s == 32'h7, "R7 flags after transfer", s, 32'h7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule